// File: doc/BRIEF.md
# Chip-Select Serial Command Receiver

This block takes a three-wire serial stream from a host: a bit clock, a data line and a select line. The block samples all three in its own system clock. Each frame opens with an 8-bit device address. If the address is accepted, a 14-bit control word follows, then a display bitmap whose length depends on the digit count carried in that control word. The control word holds a 10-bit brightness value and a 4-bit digit-count code. The bitmap holds up to 11 rows of 43 segment bits.

Incoming bits go into shadow storage. The visible registers change only when the select line falls, and only if the frame went at least as far as the end of its control word. Rows beyond the digit count just received are neither stored nor committed, so they keep their earlier contents. The downstream scan engine reads the active outputs directly and takes `commit_o` as a one-cycle notice that they have changed. There is no back-pressure on either side: the serial side cannot be stalled, and the output side is a set of held registers with no ready input, so a consumer that misses the pulse still sees the current values.

The bit clock may rest low or high between frames. Bits are taken on its rising edges while the select line is high.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `dimmer_o` is 0, `digits_o` is 11, every bit of `rows_o` is 0 and `commit_o` is low.
- R2: The first 8 bits after select rises form the address, most significant bit first. Only the value 8'b01110110 is accepted. A frame with any other address changes no output and produces no commit pulse.
- R3: After an accepted address, the next 10 bits are the brightness value, least significant bit first. It appears on `dimmer_o` after commit.
- R4: The 4 bits after the brightness value are the digit-count code, least significant bit first. Codes 4 to 11 give that many digits on `digits_o`. Every other code gives 11.
- R5: Display bit p (counting from 0 after the control word) belongs to row p/43 and segment p%43. It appears on `rows_o[43*row + segment]`.
- R6: Display bits at positions of digit count × 43 or beyond are discarded. At commit, rows whose index is at or above the new digit count keep their previous values.
- R7: The active outputs do not change while select is high. After select falls on a frame that qualifies, `commit_o` is high for exactly one cycle, and the active outputs take their new values from the next cycle.
- R8: A frame whose select line falls before the control word is complete changes no output and produces no commit pulse.
- R9: Frames are received correctly whether the bit clock rests low or high around the select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock from the host, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on the rising edge of ser_clk |
| ser_sel | input | 1 | Frame select, high for the length of a frame |
| dimmer_o | output | 10 | Active brightness value |
| digits_o | output | 4 | Active number of digits, 4 to 11 |
| rows_o | output | 473 | Active bitmap, row-major, 43 bits per row |
| commit_o | output | 1 | One-cycle pulse when the active outputs are updated |

## Verification
Several frame patterns are used, and each one separates a different fault:
- Full frames with different brightness values, digit codes and bitmap seeds show whether bits land in the right field and position.
- A frame that sends more bits than its digit count needs, followed by a frame with fewer digits, shows whether extra bits are dropped and higher rows are preserved.
- A frame with a wrong address and a frame cut off inside the control word check that nothing qualifies except a complete, accepted header.
- Out-of-range digit codes, and both resting levels of the bit clock, cover the decode fallback and edge detection that does not depend on the resting level.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  typedef enum logic [1:0] {
    PH_SKIP = 2'd0,
    PH_ADDR = 2'd1,
    PH_CTRL = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  // out-of-range digit codes fall back to the maximum count
  function automatic int unsigned fit_digits(int unsigned code, int unsigned lo, int unsigned hi);
    return (code >= lo && code <= hi) ? code : hi;
  endfunction
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= async_i[i];
        s2 <= s1;
      end
    end
    assign sync_o[i] = s2;
  end
endmodule

// File: rtl/cmdrx_frame.sv
module cmdrx_frame #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  ADDR_VAL = 8'b0111_0110,
  parameter int          DIM_W    = 10,
  parameter int          CODE_W   = 4,
  parameter int          SEGS     = 43,
  parameter int          MIN_DIG  = 4,
  parameter int          MAX_DIG  = 11,
  localparam int         ROW_BITS = SEGS * MAX_DIG,
  localparam int         DIG_W    = $clog2(MAX_DIG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk_s,
  input  logic                ser_dat_s,
  input  logic                ser_sel_s,
  output logic                commit_o,
  output logic [DIM_W-1:0]    dimmer_o,
  output logic [DIG_W-1:0]    digits_o,
  output logic [ROW_BITS-1:0] shadow_o
);
  import cmdrx_pkg::*;

  localparam int CTRL_W = DIM_W + CODE_W;
  localparam int IDX_W  = $clog2(ROW_BITS);

  phase_t             phase;
  logic [IDX_W-1:0]   idx;
  logic [ADDR_W-1:0]  addr_sh;
  logic [CTRL_W-1:0]  ctrl_sh;
  logic               ctrl_done;
  logic               ce_q, cl_q;
  logic               ce_rise, ce_fall, bit_in;
  logic [ADDR_W-1:0]  addr_next;
  logic [CODE_W-1:0]  code;
  logic [IDX_W-1:0]   last_pos;

  assign ce_rise   = ser_sel_s & ~ce_q;
  assign ce_fall   = ~ser_sel_s & ce_q;
  assign bit_in    = ser_clk_s & ~cl_q & ser_sel_s;
  assign addr_next = {addr_sh[ADDR_W-2:0], ser_dat_s};
  assign code      = ctrl_sh[CTRL_W-1 -: CODE_W];
  assign dimmer_o  = ctrl_sh[DIM_W-1:0];
  assign digits_o  = DIG_W'(fit_digits(32'(code), MIN_DIG, MAX_DIG));
  assign last_pos  = IDX_W'(32'(digits_o) * SEGS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_SKIP;
      idx       <= '0;
      addr_sh   <= '0;
      ctrl_sh   <= '0;
      ctrl_done <= 1'b0;
      ce_q      <= 1'b0;
      cl_q      <= 1'b0;
      commit_o  <= 1'b0;
      shadow_o  <= '0;
    end else begin
      ce_q     <= ser_sel_s;
      cl_q     <= ser_clk_s;
      commit_o <= ce_fall & ctrl_done;
      if (ce_rise) begin
        phase     <= PH_ADDR;
        idx       <= '0;
        ctrl_done <= 1'b0;
      end else if (ce_fall) begin
        phase <= PH_SKIP;
      end else if (bit_in) begin
        unique case (phase)
          PH_ADDR: begin
            addr_sh <= addr_next;
            if (idx == IDX_W'(ADDR_W - 1)) begin
              idx   <= '0;
              phase <= (addr_next == ADDR_VAL[ADDR_W-1:0]) ? PH_CTRL : PH_SKIP;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          PH_CTRL: begin
            ctrl_sh[idx] <= ser_dat_s;
            if (idx == IDX_W'(CTRL_W - 1)) begin
              idx       <= '0;
              ctrl_done <= 1'b1;
              phase     <= PH_DATA;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          PH_DATA: begin
            shadow_o[idx] <= ser_dat_s;
            if (idx == last_pos) phase <= PH_SKIP;
            else                 idx   <= idx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (idx <= last_pos));
  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |=> ($stable(shadow_o) && $stable(ctrl_sh)));
  assert_commit_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !ce_q);
  assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
endmodule

// File: rtl/cmdrx_rows.sv
module cmdrx_rows #(
  parameter int  SEGS     = 43,
  parameter int  MAX_DIG  = 11,
  localparam int ROW_BITS = SEGS * MAX_DIG,
  localparam int DIG_W    = $clog2(MAX_DIG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [DIG_W-1:0]    digits_i,
  input  logic [ROW_BITS-1:0] shadow_i,
  output logic [ROW_BITS-1:0] rows_o
);
  for (genvar k = 0; k < MAX_DIG; k++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rows_o[k*SEGS +: SEGS] <= '0;
      else if (load_i && (digits_i > DIG_W'(k)))
        rows_o[k*SEGS +: SEGS] <= shadow_i[k*SEGS +: SEGS];
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
  parameter int  DIM_W    = 10,
  parameter int  SEGS     = 43,
  parameter int  MAX_DIG  = 11,
  parameter int  MIN_DIG  = 4,
  localparam int ROW_BITS = SEGS * MAX_DIG,
  localparam int DIG_W    = $clog2(MAX_DIG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                ser_dat,
  input  logic                ser_sel,
  output logic [DIM_W-1:0]    dimmer_o,
  output logic [DIG_W-1:0]    digits_o,
  output logic [ROW_BITS-1:0] rows_o,
  output logic                commit_o
);
  logic [2:0]          synced;
  logic                frm_commit;
  logic [DIM_W-1:0]    sh_dimmer;
  logic [DIG_W-1:0]    sh_digits;
  logic [ROW_BITS-1:0] sh_rows;

  cmdrx_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_sel, ser_dat, ser_clk}),
    .sync_o(synced)
  );

  cmdrx_frame #(
    .DIM_W(DIM_W), .SEGS(SEGS), .MIN_DIG(MIN_DIG), .MAX_DIG(MAX_DIG)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_s(synced[0]), .ser_dat_s(synced[1]), .ser_sel_s(synced[2]),
    .commit_o(frm_commit), .dimmer_o(sh_dimmer), .digits_o(sh_digits),
    .shadow_o(sh_rows)
  );

  cmdrx_rows #(.SEGS(SEGS), .MAX_DIG(MAX_DIG)) u_rows (
    .clk(clk), .rst_n(rst_n), .load_i(frm_commit),
    .digits_i(sh_digits), .shadow_i(sh_rows), .rows_o(rows_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dimmer_o <= '0;
      digits_o <= DIG_W'(MAX_DIG);
    end else if (frm_commit) begin
      dimmer_o <= sh_dimmer;
      digits_o <= sh_digits;
    end
  end

  assign commit_o = frm_commit;

  assert_digits_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (digits_o >= DIG_W'(MIN_DIG)) && (digits_o <= DIG_W'(MAX_DIG)));
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_commit |=> ($stable(dimmer_o) && $stable(digits_o) && $stable(rows_o)));
endmodule

// File: tb/serial_cmd_rx_tb.sv
module serial_cmd_rx_tb;
  localparam int SEGS = 43;
  localparam int MAXD = 11;
  localparam int RB   = SEGS * MAXD;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ser_clk, ser_dat, ser_sel;
  logic [9:0]    dimmer_o;
  logic [3:0]    digits_o;
  logic [RB-1:0] rows_o;
  logic          commit_o;

  serial_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_sel(ser_sel), .dimmer_o(dimmer_o), .digits_o(digits_o),
    .rows_o(rows_o), .commit_o(commit_o)
  );

  int checks = 0, errors = 0, commits = 0;
  logic [9:0]    e_dim = '0;
  int            e_dig = 11;
  logic [RB-1:0] e_rows = '0, e_shadow = '0;

  always @(negedge clk) if (commit_o === 1'b1) commits++;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "dimmer", 64'(dimmer_o), 64'(e_dim));
    chk(req, "digits", 64'(digits_o), 64'(e_dig));
    for (int k = 0; k < MAXD; k++)
      chk(req, $sformatf("row %0d", k), 64'(rows_o[k*SEGS +: SEGS]), 64'(e_rows[k*SEGS +: SEGS]));
  endtask

  function automatic bit pat(int p, int seed);
    return ((p * 5 + seed) % 7) < 3;
  endfunction

  function automatic bit frame_bit(int i, logic [7:0] a, logic [9:0] d, logic [3:0] c, int seed);
    if (i < 8)  return a[7-i];
    if (i < 18) return d[i-8];
    if (i < 22) return c[i-18];
    return pat(i - 22, seed);
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // total = number of bits clocked before select falls
  task automatic send(logic [7:0] a, logic [9:0] d, logic [3:0] c, int total,
                      int seed, bit idle_high, string req);
    int c0 = commits;
    int dig;
    bit ok;
    ser_clk = idle_high;
    wait_clk(4);
    ser_sel = 1'b1;
    wait_clk(4);
    for (int i = 0; i < total; i++) begin
      ser_clk = 1'b0;
      ser_dat = frame_bit(i, a, d, c, seed);
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
    end
    if (!idle_high) ser_clk = 1'b0;
    wait_clk(4);
    chk_all("R7");
    chk("R7", "commit before fall", 64'(commits - c0), 64'd0);
    ser_sel = 1'b0;
    wait_clk(10);
    ok = (a == 8'b0111_0110) && (total >= 22);
    if (ok) begin
      dig = (c >= 4 && c <= 11) ? int'(c) : 11;
      for (int p = 0; p < total - 22 && p < dig * SEGS; p++) e_shadow[p] = pat(p, seed);
      for (int k = 0; k < dig; k++) e_rows[k*SEGS +: SEGS] = e_shadow[k*SEGS +: SEGS];
      e_dim = d;
      e_dig = dig;
    end
    chk(req, "commit pulses", 64'(commits - c0), ok ? 64'd1 : 64'd0);
    chk_all(req);
  endtask

  task automatic t_reset;
    chk("R1", "commit", 64'(commit_o), 64'd0);
    chk_all("R1");
  endtask

  task automatic t_basic;        // R3 R4 R5, extra bits past 6 rows dropped (R6)
    send(8'b0111_0110, 10'h2A5, 4'b0110, 22 + RB, 1, 1'b0, "R5");
  endtask

  task automatic t_idle_high;    // R9 with all 11 rows
    send(8'b0111_0110, 10'h3C1, 4'b1011, 22 + RB, 3, 1'b1, "R9");
  endtask

  task automatic t_shrink;       // R6: rows 4..10 keep previous content
    send(8'b0111_0110, 10'h005, 4'b0100, 22 + 4 * SEGS, 5, 1'b0, "R6");
  endtask

  task automatic t_bad_addr;     // R2
    send(8'b0111_0111, 10'h155, 4'b1000, 22 + RB, 2, 1'b1, "R2");
  endtask

  task automatic t_partial;      // R8: cut inside the control word
    send(8'b0111_0110, 10'h0FF, 4'b0101, 20, 4, 1'b0, "R8");
  endtask

  task automatic t_code_oob;     // R4 fallback to 11 digits, R3 new value
    send(8'b0111_0110, 10'h21B, 4'b0011, 22 + RB, 6, 1'b0, "R4");
    send(8'b0111_0110, 10'h0E7, 4'b1111, 22 + RB, 0, 1'b1, "R3");
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_sel = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_basic();
    t_idle_high();
    t_shrink();
    t_bad_addr();
    t_partial();
    t_code_oob();
    finish_run();
  end
endmodule